// File: doc/BRIEF.md
# Address-Event Receiver with Embedded Synaptic Weight

This block is the input port of a spiking neuron array. A sender outside the clock domain presents an event word and raises a request line; the receiver brings the request into the system clock with a two-flop synchroniser, captures the word at the moment it accepts the request, and completes a four-phase handshake with an acknowledge line. The captured word names a target neuron, a target synapse on that neuron, and a weight.

The neuron and synapse indices are decoded into one-hot row and column selects. When the addressed synapse belongs to the programmable subset, the weight field is presented on the weight output together with a one-cycle load strobe. The stimulation strobe always follows one cycle later, so the weight is in place before the synapse fires. For the other synapses the weight field is dropped and no load strobe appears. A new request is taken only once the previous handshake has gone back to idle.

Top module: `aer_weight_rx`

## Requirements
- R1: The 12-bit event word holds the neuron index in bits [11:8], the synapse index in bits [7:5] and the weight in bits [4:0].
- R2: The word is captured in the cycle the request is accepted; changes on the word input after that cycle do not alter the selects or weight of that event.
- R3: While an event is in progress, `nrn_sel` has exactly bit `neuron` set and `syn_sel` exactly bit `synapse` set; while idle both are zero.
- R4: For a programmable synapse (indices 0 and 1 by default), `wt_load` is high for one cycle, starting on the third rising clock edge after the request rises, with `wt_val` equal to the weight field in that cycle.
- R5: For a non-programmable synapse no `wt_load` pulse occurs and `wt_val` keeps the previously loaded weight.
- R6: `stim` is high for exactly one cycle per event, in the cycle after the load slot (fourth rising edge after the request rises), whether or not a load occurred.
- R7: `ev_ack` rises in the cycle after `stim`, stays high while the request stays high, and falls on the third rising edge after the request falls.
- R8: A request held high produces only one event; a request raised as soon as the acknowledge falls is accepted as a new event.
- R9: During and after reset, `ev_ack`, `stim`, `wt_load`, both selects and `wt_val` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_req | input | 1 | Asynchronous event request |
| ev_word | input | 12 | Event word: neuron, synapse, weight |
| ev_ack | output | 1 | Handshake acknowledge |
| nrn_sel | output | 16 | One-hot neuron (row) select |
| syn_sel | output | 8 | One-hot synapse (column) select |
| wt_val | output | 5 | Weight for the programmable synapse |
| wt_load | output | 1 | Weight load strobe |
| stim | output | 1 | Synapse stimulation strobe |

## Verification
The release of one handshake and the acceptance of the next can fall into the same few cycles: the acknowledge dropping to idle while the sender already raises its next request. The bench sweeps every neuron and synapse pair back to back, raising each new request on the very sample where the acknowledge was seen low, and judges that the new event still yields exactly one stimulation pulse with its own selects and the correct load behaviour. It also corrupts the word input right after capture and holds requests for varying lengths to separate latching and single acceptance from the handshake timing.

// File: rtl/aer_rx_pkg.sv
// Shared types for the address-event receiver.
// Assumes: handshake sequencing is a four-state machine.
package aer_rx_pkg;
    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_LOAD = 2'd1,
        HS_STIM = 2'd2,
        HS_ACK  = 2'd3
    } hs_state_t;
endpackage

// File: rtl/aer_req_sync.sv
// Multi-stage synchroniser for the asynchronous request line.
// Assumes: input toggles no faster than the handshake allows; STAGES >= 2.
module aer_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // shift the raw request through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/aer_hs_fsm.sv
// Four-phase handshake sequencer: accept, load slot, stimulate, acknowledge.
// Assumes: req_s is already synchronous; sender keeps req high until ack.
module aer_hs_fsm
    import aer_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_s,
    output logic      accept,
    output hs_state_t state
);
    hs_state_t state_q, state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: if (req_s)  state_d = HS_LOAD;
            HS_LOAD:             state_d = HS_STIM;
            HS_STIM:             state_d = HS_ACK;
            HS_ACK:  if (!req_s) state_d = HS_IDLE;
            default:             state_d = HS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    assign accept = (state_q == HS_IDLE) && req_s;
    assign state  = state_q;
endmodule

// File: rtl/aer_addr_decode.sv
// Index to one-hot decoder with an enable; output is zero when disabled.
// Assumes: OUT_N <= 2**IDX_W.
module aer_addr_decode #(
    parameter int OUT_N = 16,
    parameter int IDX_W = $clog2(OUT_N)
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [OUT_N-1:0] onehot
);
    for (genvar i = 0; i < OUT_N; i++) begin : g_bit
        assign onehot[i] = en && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/aer_weight_rx.sv
// Address-event receiver: synchronises the request, captures the event word,
// decodes neuron/synapse selects, loads the weight for programmable synapses
// one cycle before the stimulation strobe, then acknowledges.
// Assumes: four-phase sender; word stable while request is high until capture.
module aer_weight_rx
    import aer_rx_pkg::*;
#(
    parameter int                NRN_N     = 16,
    parameter int                SYN_N     = 8,
    parameter int                WT_W      = 5,
    parameter logic [SYN_N-1:0]  PROG_MASK = 8'b0000_0011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_req,
    input  logic [11:0]      ev_word,
    output logic             ev_ack,
    output logic [NRN_N-1:0] nrn_sel,
    output logic [SYN_N-1:0] syn_sel,
    output logic [WT_W-1:0]  wt_val,
    output logic             wt_load,
    output logic             stim
);
    localparam int NRN_W  = $clog2(NRN_N);
    localparam int SYN_W  = $clog2(SYN_N);
    localparam int WORD_W = NRN_W + SYN_W + WT_W;
    localparam int SYN_LO = WT_W;
    localparam int NRN_LO = WT_W + SYN_W;

    logic            req_s;
    logic            accept;
    hs_state_t       state;
    logic [WORD_W-1:0] word_q;
    logic [WT_W-1:0] wt_q;
    logic            busy;
    logic [SYN_W-1:0] in_syn;
    logic [SYN_W-1:0] syn_idx;
    logic [NRN_W-1:0] nrn_idx;

    aer_req_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ev_req), .sync_out(req_s)
    );

    aer_hs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_s(req_s), .accept(accept), .state(state)
    );

    assign in_syn  = ev_word[NRN_LO-1:SYN_LO];
    assign syn_idx = word_q[NRN_LO-1:SYN_LO];
    assign nrn_idx = word_q[WORD_W-1:NRN_LO];

    // capture the event word at acceptance only
    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (accept) word_q <= ev_word[WORD_W-1:0];
    end

    // keep the weight of the last programmable event
    always_ff @(posedge clk) begin
        if (!rst_n)                           wt_q <= '0;
        else if (accept && PROG_MASK[in_syn]) wt_q <= ev_word[WT_W-1:0];
    end

    assign busy = (state != HS_IDLE);

    aer_addr_decode #(.OUT_N(NRN_N), .IDX_W(NRN_W)) u_row (
        .en(busy), .idx(nrn_idx), .onehot(nrn_sel)
    );

    aer_addr_decode #(.OUT_N(SYN_N), .IDX_W(SYN_W)) u_col (
        .en(busy), .idx(syn_idx), .onehot(syn_sel)
    );

    assign wt_val  = wt_q;
    assign wt_load = (state == HS_LOAD) && PROG_MASK[syn_idx];
    assign stim    = (state == HS_STIM);
    assign ev_ack  = (state == HS_ACK);
endmodule

// File: rtl/aer_weight_rx_chk.sv
// Protocol checker for the address-event receiver, bound to the top module.
module aer_weight_rx_chk #(
    parameter int                NRN_N     = 16,
    parameter int                SYN_N     = 8,
    parameter int                WT_W      = 5,
    parameter logic [SYN_N-1:0]  PROG_MASK = 8'b0000_0011
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_req,
    input logic             ev_ack,
    input logic [NRN_N-1:0] nrn_sel,
    input logic [SYN_N-1:0] syn_sel,
    input logic [WT_W-1:0]  wt_val,
    input logic             wt_load,
    input logic             stim
);
    // R6
    load_then_stim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wt_load |=> stim);
    // R6
    stim_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stim |=> !stim);
    // R7
    stim_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stim |=> ev_ack);
    // R7
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ev_ack) |-> !$past(ev_req, 2));
    // R5
    load_prog_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wt_load |-> ((syn_sel & PROG_MASK) != '0));
    // R5
    wt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wt_load |-> $stable(wt_val));
    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stim |-> ($countones(nrn_sel) == 1 && $countones(syn_sel) == 1));
    // R3
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wt_load, stim, ev_ack}));
endmodule

bind aer_weight_rx aer_weight_rx_chk #(
    .NRN_N(NRN_N), .SYN_N(SYN_N), .WT_W(WT_W), .PROG_MASK(PROG_MASK)
) u_chk (.*);

// File: tb/aer_weight_rx_test.sv
// Sweep of every neuron/synapse pair through the receiver, back to back.
module aer_weight_rx_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_req = 1'b0;
    logic [11:0] ev_word = '0;
    logic        ev_ack;
    logic [15:0] nrn_sel;
    logic [7:0]  syn_sel;
    logic [4:0]  wt_val;
    logic        wt_load;
    logic        stim;

    int total = 0;
    int bad   = 0;
    logic [4:0] last_wt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aer_weight_rx uut (
        .clk(clk), .rst_n(rst_n), .ev_req(ev_req), .ev_word(ev_word),
        .ev_ack(ev_ack), .nrn_sel(nrn_sel), .syn_sel(syn_sel),
        .wt_val(wt_val), .wt_load(wt_load), .stim(stim)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_event(input int n, input int s, input int hold);
        logic [4:0]  w;
        logic [11:0] word;
        logic        prog;
        int          stims;
        w     = 5'((n * 11 + s * 7 + 3) % 32);
        word  = {4'(n), 3'(s), w};          // R1 field layout
        prog  = (s < 2);
        stims = 0;
        ev_word = word;
        ev_req  = 1'b1;
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            if (stim) stims++;
            if (i < 3) chk("R8 idle before accept", {30'd0, wt_load, ev_ack}, 0);
            if (i == 3) begin
                chk("R4 load slot", wt_load, prog);
                if (prog) last_wt = w;
                chk("R5/R4 weight value", wt_val, last_wt);
                chk("R3 row select", nrn_sel, 32'(16'd1 << n));
                ev_word = ~word;             // R2: corrupt after capture
            end
            if (i == 4) begin
                chk("R6 stim slot", stim, 1);
                chk("R2 row kept", nrn_sel, 32'(16'd1 << n));
                chk("R2 col kept", syn_sel, 32'(8'd1 << s));
                chk("R5 weight held", wt_val, last_wt);
            end
            if (i == 5) chk("R7 ack rise", ev_ack, 1);
        end
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (stim) stims++;
            chk("R7 ack held", ev_ack, 1);
        end
        chk("R8 single stim", stims, 1);
        ev_req = 1'b0;
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            chk("R7 ack release", ev_ack, (i < 3) ? 1 : 0);
        end
        chk("R3 idle selects", {nrn_sel, syn_sel}, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                // R9 reset state
                chk("R9 reset outputs", {ev_ack, stim, wt_load, wt_val, nrn_sel, syn_sel}, 0);
                rst_n = 1'b1;
                @(negedge clk);
                chk("R9 after reset", {ev_ack, stim, wt_load, wt_val}, 0);
                for (int n = 0; n < 16; n++)
                    for (int s = 0; s < 8; s++)
                        run_event(n, s, (n + s) % 4);
            end
            begin
                repeat (100000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=expired expected=done");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule